// File: doc/BRIEF.md
# Two-Speed Clock Start-Up Sequencer

This block decides which clock source feeds the core after a reset and after every wake from sleep. When the crystal oscillator has to start from cold, the core does not have to wait for it: the sequencer hands the core the internal RC clock at once. In parallel it counts primary-oscillator periods in a start-up timer. If PLL mode is selected, it then waits out a lock interval. After that it moves the core onto the primary source by itself and sets a status output that software can read.

Two-speed operation needs two things: the enable configuration input must be set, and the oscillator mode must be one of the crystal modes. If either is missing, the core stays held until the primary source is usable. For a non-crystal primary source that happens at once. While the core runs from the internal clock, software may steer the clock-select bits or send the part back to sleep before the timer expires. The block honours either action. A wake then starts the whole sequence again from the beginning. The start-up counter runs in the primary-oscillator domain, and its completion flag crosses into the system domain through two flops.

Top module: `two_speed_clk_seq`

## Requirements
- R1: After reset, `clk_src` is 3 (core held), `prim_ready` is 0, and both stay that way until `pwrt_done` is seen high.
- R2: With `ts_enable`=1 and a crystal mode (`osc_mode` 0 LP, 1 XT, 2 HS, 3 HS+PLL), `clk_src` becomes 2 (internal RC) when the sequence starts on `pwrt_done` or on a wake.
- R3: In a crystal mode, `clk_src` becomes 0 (primary) no earlier than `OST_CYCLES` primary-clock periods after the internal phase starts, and it does so without any software action.
- R4: With `osc_mode`=3, the switch to primary comes a further `PLL_CYCLES` system-clock cycles after the start-up timer completes.
- R5: With `ts_enable`=0 or a non-crystal mode (`osc_mode` 4 to 7), the internal clock is never used as a fallback. `clk_src` goes from 3 straight to 0. For a crystal mode this happens after the start-up timer; for a non-crystal mode it happens within a few cycles.
- R6: `prim_ready` is 1 exactly while `clk_src` is 0, and 0 during the internal phase.
- R7: In the internal phase, `sel_bits`=01 selects the secondary source (`clk_src`=1) and the block stays there after the timer completes. `sel_bits`=00 moves the core to primary once the timer is done, and `sel_bits` 1x selects the internal source.
- R8: A `sleep_req` pulse during the internal phase sets `clk_src` to 3 and clears the start-up and PLL counters. The next `wake_evt` restarts a full `OST_CYCLES` count.
- R9: `int_freq` is 0 after reset. It loads `ifreq_in` only when `ifreq_wr` is high.
- R10: A `sleep_req` pulse while running from the primary source sets `clk_src` to 3. A later `wake_evt` repeats the internal phase and then the automatic switch to primary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System (internal RC) clock for the sequencer |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrt_done | input | 1 | Power-up timer has expired |
| prim_clk | input | 1 | Primary oscillator clock |
| ts_enable | input | 1 | Two-speed enable configuration bit |
| osc_mode | input | 3 | Primary oscillator mode: 0-3 crystal (3 with PLL), 4-7 other |
| sel_bits | input | 2 | Software clock select: 00 primary, 01 secondary, 1x internal |
| sleep_req | input | 1 | Sleep request pulse |
| wake_evt | input | 1 | Wake event pulse |
| ifreq_wr | input | 1 | Write strobe for the internal frequency select |
| ifreq_in | input | 3 | New internal frequency select value |
| clk_src | output | 2 | Mux control: 0 primary, 1 secondary, 2 internal, 3 held |
| prim_ready | output | 1 | Status: primary oscillator is clocking the core |
| int_freq | output | 3 | Internal RC frequency select |

## Verification
The checker looks at a set of rules on every cycle. The core stays held until the power-up timer is seen, a crystal primary source is never selected before the synchronized timer flag, and the internal clock never appears as a fallback when two-speed is off. A sleep request from an active source always gates the clock within two cycles, and the frequency select changes only on a write. Some things only the scenarios can show: the number of primary periods actually counted, the extra PLL interval, the restart of a full count after sleeping mid-phase, and the order of source changes under software steering. For these, the bench keeps a queue of expected source and status transitions and measures the time between them.

// File: rtl/two_speed_clk_seq.sv
module two_speed_clk_seq #(
  parameter int OST_CYCLES = 1024,
  parameter int PLL_CYCLES = 64
) (
  input  logic       clk_sys,
  input  logic       rst_n,
  input  logic       pwrt_done,
  input  logic       prim_clk,
  input  logic       ts_enable,
  input  logic [2:0] osc_mode,
  input  logic [1:0] sel_bits,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic       ifreq_wr,
  input  logic [2:0] ifreq_in,
  output logic [1:0] clk_src,
  output logic       prim_ready,
  output logic [2:0] int_freq
);
  localparam int OW = $clog2(OST_CYCLES + 1);
  localparam int PW = $clog2(PLL_CYCLES + 1);
  localparam logic [1:0] SRC_PRI = 2'd0, SRC_SEC = 2'd1, SRC_INT = 2'd2, SRC_OFF = 2'd3;

  typedef enum logic [2:0] {S_PWRT, S_INT, S_WAIT, S_PLL, S_RUN, S_SLEEP} st_t;

  st_t         st;
  logic        ts_act, wake_pend;
  logic [PW-1:0] pll_cnt;

  wire crystal  = (osc_mode <= 3'd3);
  wire pll_mode = (osc_mode == 3'd3);
  wire ts_ok    = ts_enable && crystal;
  wire ost_run  = (st == S_INT) || (st == S_WAIT) || (st == S_PLL) || (st == S_RUN);

  // primary-oscillator domain start-up timer
  logic          run_p1, run_p2, ost_done_p;
  logic [OW-1:0] ost_cnt;

  always_ff @(posedge prim_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_p1     <= 1'b0;
      run_p2     <= 1'b0;
      ost_cnt    <= '0;
      ost_done_p <= 1'b0;
    end else begin
      run_p1 <= ost_run;
      run_p2 <= run_p1;
      if (!run_p2) begin
        ost_cnt    <= '0;
        ost_done_p <= 1'b0;
      end else if (!ost_done_p) begin
        if (ost_cnt == OW'(OST_CYCLES - 1)) ost_done_p <= 1'b1;
        else ost_cnt <= ost_cnt + 1'b1;
      end
    end
  end

  logic done_s1, ost_done_s;
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      done_s1    <= 1'b0;
      ost_done_s <= 1'b0;
    end else begin
      done_s1    <= ost_done_p;
      ost_done_s <= done_s1;
    end
  end

  wire ost_ok = !crystal || ost_done_s;
  wire start  = (st == S_PWRT)  ? (pwrt_done && !ost_done_s)
              : (st == S_SLEEP) ? ((wake_evt || wake_pend) && !ost_done_s)
              : 1'b0;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PWRT;
      ts_act    <= 1'b0;
      wake_pend <= 1'b0;
      pll_cnt   <= '0;
    end else if (start) begin
      ts_act    <= ts_ok;
      wake_pend <= 1'b0;
      pll_cnt   <= '0;
      st        <= ts_ok ? S_INT : S_WAIT;
    end else begin
      case (st)
        S_INT, S_WAIT: begin
          pll_cnt <= '0;
          if (sleep_req)   st <= S_SLEEP;
          else if (ost_ok) st <= pll_mode ? S_PLL : S_RUN;
        end
        S_PLL: begin
          if (sleep_req) begin
            st      <= S_SLEEP;
            pll_cnt <= '0;
          end else if (pll_cnt == PW'(PLL_CYCLES - 1)) st <= S_RUN;
          else pll_cnt <= pll_cnt + 1'b1;
        end
        S_RUN:   if (sleep_req) st <= S_SLEEP;
        S_SLEEP: if (wake_evt) wake_pend <= 1'b1;
        default: ;
      endcase
    end
  end

  wire [1:0] sel_src = (sel_bits == 2'b00) ? SRC_PRI
                     : (sel_bits == 2'b01) ? SRC_SEC : SRC_INT;
  wire [1:0] early_src = (sel_bits == 2'b01) ? SRC_SEC : SRC_INT;

  logic [1:0] src_nxt;
  always_comb begin
    case (st)
      S_INT:   src_nxt = early_src;
      S_PLL:   src_nxt = ts_act ? early_src : SRC_OFF;
      S_RUN:   src_nxt = sel_src;
      default: src_nxt = SRC_OFF;
    endcase
  end

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      clk_src    <= SRC_OFF;
      prim_ready <= 1'b0;
      int_freq   <= 3'd0;
    end else begin
      clk_src    <= src_nxt;
      prim_ready <= (src_nxt == SRC_PRI);
      if (ifreq_wr) int_freq <= ifreq_in;
    end
  end
endmodule

// File: rtl/two_speed_clk_seq_chk.sv
module two_speed_clk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrt_done,
  input logic       ts_enable,
  input logic [2:0] osc_mode,
  input logic [1:0] sel_bits,
  input logic       sleep_req,
  input logic       wake_evt,
  input logic       ifreq_wr,
  input logic [1:0] clk_src,
  input logic       prim_ready,
  input logic [2:0] int_freq,
  input logic       done_s
);
  logic started;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) started <= 1'b0;
    else if (pwrt_done) started <= 1'b1;

  wire crystal = (osc_mode <= 3'd3);

  a_r1_held_until_pwrt: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (clk_src == 2'd3 && !prim_ready));

  a_r3_pri_after_ost: assert property (@(posedge clk) disable iff (!rst_n)
    (crystal && clk_src == 2'd0) |-> done_s);

  a_r5_no_int_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ts_enable && crystal) && sel_bits == 2'b00 && $past(sel_bits) == 2'b00) |-> (clk_src != 2'd2));

  a_r8_sleep_gates_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !wake_evt && clk_src != 2'd3) |=> ##1 (clk_src == 2'd3));

  a_r9_freq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ifreq_wr |=> $stable(int_freq));
endmodule

bind two_speed_clk_seq two_speed_clk_seq_chk u_chk (
  .clk(clk_sys), .rst_n(rst_n), .pwrt_done(pwrt_done), .ts_enable(ts_enable),
  .osc_mode(osc_mode), .sel_bits(sel_bits), .sleep_req(sleep_req), .wake_evt(wake_evt),
  .ifreq_wr(ifreq_wr), .clk_src(clk_src), .prim_ready(prim_ready), .int_freq(int_freq),
  .done_s(ost_done_s)
);

// File: tb/sim_two_speed_clk_seq.sv
module sim_two_speed_clk_seq;
  localparam int OST = 1024;
  localparam int PLL = 40;
  localparam logic [2:0] E_PRI = 3'b001, E_SEC = 3'b010, E_INT = 3'b100, E_OFF = 3'b110;

  logic clk = 1'b0, prim = 1'b0;
  always #10 clk = ~clk;
  always #7 prim = ~prim;

  logic rst_n = 1'b0, pwrt_done = 1'b0, ts_enable = 1'b0, sleep_req = 1'b0, wake_evt = 1'b0;
  logic ifreq_wr = 1'b0;
  logic [2:0] osc_mode = 3'd1, ifreq_in = 3'd0;
  logic [1:0] sel_bits = 2'b00;
  logic [1:0] clk_src;
  logic prim_ready;
  logic [2:0] int_freq;

  two_speed_clk_seq #(.OST_CYCLES(OST), .PLL_CYCLES(PLL)) u0 (
    .clk_sys(clk), .rst_n(rst_n), .pwrt_done(pwrt_done), .prim_clk(prim),
    .ts_enable(ts_enable), .osc_mode(osc_mode), .sel_bits(sel_bits),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .ifreq_wr(ifreq_wr), .ifreq_in(ifreq_in),
    .clk_src(clk_src), .prim_ready(prim_ready), .int_freq(int_freq));

  int sys_cyc = 0, prim_cyc = 0;
  always @(posedge clk) sys_cyc++;
  always @(posedge prim) prim_cyc++;

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [2:0] exp_q[$];
  string tag_q[$];
  string last_tag = "R1";
  logic [2:0] last = E_OFF;
  bit mon_on = 1'b0;
  int evt_n = 0, evt_sys = 0, evt_prim = 0;

  task automatic push(logic [2:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on && ({clk_src, prim_ready} !== last)) begin
      if (exp_q.size() == 0) chk(1'b0, {last_tag, " unexpected switch"}, {clk_src, prim_ready}, last);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        last_tag = tag_q.pop_front();
        chk({clk_src, prim_ready} === e, last_tag, {clk_src, prim_ready}, e);
      end
      last = {clk_src, prim_ready};
      evt_sys = sys_cyc;
      evt_prim = prim_cyc;
      evt_n++;
    end
  end

  task automatic await_evt();
    int n0 = evt_n;
    while (evt_n == n0) @(negedge clk);
  endtask

  task automatic do_reset(bit en, logic [2:0] mode);
    @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0; ts_enable = en; osc_mode = mode; pwrt_done = 1'b0;
    sel_bits = 2'b00; sleep_req = 1'b0; wake_evt = 1'b0; ifreq_wr = 1'b0;
    exp_q.delete(); tag_q.delete();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    last = E_OFF;
    mon_on = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", sys_cyc, 0);
    finish_run();
  end

  initial begin
    int p0, s0, xt_sys, d;
    // R1 and R9: reset state
    do_reset(1'b1, 3'd1);
    chk(clk_src == 2'd3, "R1 src", clk_src, 3);
    chk(prim_ready == 1'b0, "R1 status", prim_ready, 0);
    chk(int_freq == 3'd0, "R9 reset freq", int_freq, 0);
    repeat (50) @(negedge clk);
    chk(clk_src == 2'd3, "R1 held without pwrt", clk_src, 3);

    // R2, R3, R6: basic two-speed on XT
    push(E_INT, "R2"); push(E_PRI, "R3");
    pwrt_done = 1'b1;
    await_evt();
    p0 = evt_prim; s0 = evt_sys;
    chk(prim_ready == 1'b0, "R6 status low on internal", prim_ready, 0);
    await_evt();
    d = evt_prim - p0;
    chk(d >= OST && d <= OST + 16, "R3 primary periods counted", d, OST);
    xt_sys = evt_sys - s0;
    chk(prim_ready == 1'b1, "R6 status high on primary", prim_ready, 1);

    // R9: frequency select write
    ifreq_in = 3'd5; ifreq_wr = 1'b1; @(negedge clk); ifreq_wr = 1'b0;
    ifreq_in = 3'd2;
    repeat (3) @(negedge clk);
    chk(int_freq == 3'd5, "R9 write loads and holds", int_freq, 5);

    // R10: sleep from primary run, wake repeats sequence
    push(E_OFF, "R10"); push(E_INT, "R10"); push(E_PRI, "R10");
    pulse_sleep();
    await_evt();
    repeat (20) @(negedge clk);
    pulse_wake();
    await_evt();
    p0 = evt_prim;
    await_evt();
    d = evt_prim - p0;
    chk(d >= OST && d <= OST + 16, "R10 full restart after wake", d, OST);

    // R8: sleep in the middle of the internal phase
    push(E_OFF, "R8"); push(E_INT, "R8");
    pulse_sleep();
    await_evt();
    repeat (20) @(negedge clk);
    pulse_wake();
    await_evt();
    repeat (100) @(negedge clk);
    push(E_OFF, "R8");
    pulse_sleep();
    await_evt();
    repeat (800) @(negedge clk);
    chk(clk_src == 2'd3, "R8 stays gated in sleep", clk_src, 3);
    push(E_INT, "R8"); push(E_PRI, "R8");
    pulse_wake();
    await_evt();
    p0 = evt_prim;
    await_evt();
    d = evt_prim - p0;
    chk(d >= OST && d <= OST + 16, "R8 counter cleared by sleep", d, OST);

    // R7: software steering during the internal phase
    do_reset(1'b1, 3'd1);
    chk(int_freq == 3'd0, "R9 reset clears freq", int_freq, 0);
    push(E_INT, "R7");
    pwrt_done = 1'b1;
    await_evt();
    push(E_SEC, "R7");
    sel_bits = 2'b01;
    await_evt();
    repeat (900) @(negedge clk);
    chk({clk_src, prim_ready} == E_SEC, "R7 stays on secondary after timer", {clk_src, prim_ready}, E_SEC);
    push(E_PRI, "R7");
    sel_bits = 2'b00;
    await_evt();
    push(E_INT, "R7");
    sel_bits = 2'b10;
    await_evt();
    push(E_PRI, "R7");
    sel_bits = 2'b00;
    await_evt();

    // R4: PLL mode adds the lock interval
    do_reset(1'b1, 3'd3);
    push(E_INT, "R4"); push(E_PRI, "R4");
    pwrt_done = 1'b1;
    await_evt();
    s0 = evt_sys;
    await_evt();
    d = evt_sys - s0;
    chk(d >= xt_sys + PLL - 3 && d <= xt_sys + PLL + 3, "R4 PLL lock interval", d, xt_sys + PLL);

    // R5: two-speed disabled on a crystal mode
    do_reset(1'b0, 3'd1);
    push(E_PRI, "R5");
    p0 = prim_cyc;
    pwrt_done = 1'b1;
    await_evt();
    d = evt_prim - p0;
    chk(d >= OST, "R5 crystal waits for timer without fallback", d, OST);

    // R5: non-crystal mode with enable set
    do_reset(1'b1, 3'd4);
    push(E_PRI, "R5");
    s0 = sys_cyc;
    pwrt_done = 1'b1;
    await_evt();
    d = evt_sys - s0;
    chk(d <= 6, "R5 non-crystal switches at once", d, 3);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected switches seen", exp_q.size(), 0);
    finish_run();
  end
endmodule